// File: doc/BRIEF.md
# GPIO Data and Direction Register Bank

This block is the register side of a general-purpose pin controller with up to fifty pins, accessed through a 16-bit register port. The lower thirty-two pins can each be an input or an output. Each has a direction bit and a data bit. When a data register is read, the synchronised pad level comes back for pins set as inputs and the latched drive value comes back for pins set as outputs. Pins 32 and above can only drive. Pins 32–47 take their data from one output register. Pins 48 and 49 take their data from the low bits of a second output register, and their drive enables from bits 8 and 9 of that same register.

A build parameter selects the variant: fifty pins with pull control, thirty-six pins, or forty-eight pins. A second parameter adds a dedicated enable register for pins 32–47. Without that register, those pins drive at all times. In the fifty-pin variant, pins 0–14 also have a pull enable and a pull-up/pull-down select. Register writes always carry all 16 bits. Reads are combinational from the address. Software is expected to load the data register first and then switch the pin to output, so the data register keeps its value while the pin is an input.

Top module: `gpio_bank_top`

## Requirements
- R1: After reset, every stored bit is 0. All pins 0–31 are inputs, pads 48–49 are not driven, pulls are off, and every register except the two pin-data registers reads 0.
- R2: A write to 0x000 sets the direction of pins 0–15, and a write to 0x002 sets pins 16–31. A bit of 1 enables the output of that pin's pad on the next cycle.
- R3: A write to 0x004 (pins 0–15) or 0x006 (pins 16–31) stores the drive value whatever the direction. The value appears on the pad outputs on the next cycle and is held, unchanged, across direction changes.
- R4: A read of 0x004 or 0x006 returns the stored value for output pins. For input pins it returns the pad level after a two-stage synchroniser, so a pad change is first visible two clock edges after it is applied.
- R5: Bit i of register 0x01C drives pin 32+i. Bits 0 and 1 of register 0x01E drive pins 48 and 49. Both registers read back what was stored.
- R6: When the dedicated enable register at 0x020 is built, its bit i enables the output of pin 32+i. Otherwise, every implemented pin from 32 to 47 is enabled permanently.
- R7: Bits 8 and 9 of register 0x01E enable the outputs of pins 48 and 49, and take effect on the next cycle.
- R8: Pins at or above the variant's pin count never drive and read as 0. Writes to their bits have no effect.
- R9: In the fifty-pin variant, bit i of 0x1E0 turns on the pull for pin i (i < 15), and bit i of 0x1E2 picks pull-up (1) or pull-down (0). Bit 15 of both registers is ignored. In the other variants, both registers read 0 and have no effect.
- R10: Unimplemented bits read 0. Addresses with no register read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 9 | Register byte address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data for addr |
| pad_in | input | 32 | Pad levels of bidirectional pins 0–31 |
| pad_out | output | 50 | Drive value per pin |
| pad_oe | output | 50 | Output enable per pin |
| pull_en | output | 15 | Pull enable, pins 0–14 |
| pull_up | output | 15 | Pull direction (1 up, 0 down), pins 0–14 |

## Verification
The bench builds two instances side by side. One is the fifty-pin variant with pull control and shared enable bits. The other is the thirty-six-pin variant with the dedicated enable register. The first covers pull control, pins 48–49 and the always-driven pins 32–47. The second covers the separate enable register, writes above the pin count, and the pull registers when they are absent. A bench model predicts every register read and pad vector of both instances after each write and each pad change.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int MAX_PINS   = 50;
  localparam int REG_W      = 16;
  localparam int ADDR_W     = 9;
  localparam int BIDIR_PINS = 32;
  localparam int PULL_PINS  = 15;

  localparam logic [ADDR_W-1:0] OFS_DIR_LO = 9'h000;
  localparam logic [ADDR_W-1:0] OFS_DIR_HI = 9'h002;
  localparam logic [ADDR_W-1:0] OFS_DAT_LO = 9'h004;
  localparam logic [ADDR_W-1:0] OFS_DAT_HI = 9'h006;
  localparam logic [ADDR_W-1:0] OFS_OUT_LO = 9'h01C;
  localparam logic [ADDR_W-1:0] OFS_OUT_HI = 9'h01E;
  localparam logic [ADDR_W-1:0] OFS_OE_SEP = 9'h020;
  localparam logic [ADDR_W-1:0] OFS_PL_EN  = 9'h1E0;
  localparam logic [ADDR_W-1:0] OFS_PL_UP  = 9'h1E2;

  typedef enum logic [1:0] {
    GV_W50_PULL = 2'd0,
    GV_W36      = 2'd1,
    GV_W48      = 2'd2
  } gpio_variant_e;

  function automatic int variant_pins(gpio_variant_e v);
    case (v)
      GV_W50_PULL: return 50;
      GV_W36:      return 36;
      default:     return 48;
    endcase
  endfunction

  function automatic bit variant_has_pull(gpio_variant_e v);
    return v == GV_W50_PULL;
  endfunction

  // bit i set when pin base+i exists in a bank of npins
  function automatic logic [REG_W-1:0] lane_mask(int base, int npins);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < REG_W; i++) begin
      if (base + i < npins) m[i] = 1'b1;
    end
    return m;
  endfunction

  // upper output register: data in low byte, enables in high byte
  function automatic logic [REG_W-1:0] hi_out_mask(int npins);
    logic [REG_W-1:0] d;
    d = lane_mask(48, npins) & 16'h00FF;
    return d | (d << 8);
  endfunction

  // output pins return the drive value, input pins the synced pad
  function automatic logic [REG_W-1:0] merge_read(logic [REG_W-1:0] dat,
                                                  logic [REG_W-1:0] dir,
                                                  logic [REG_W-1:0] pad);
    return (dat & dir) | (pad & ~dir);
  endfunction

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_field_reg.sv
module gpio_field_reg #(
  parameter int              W    = 16,
  parameter logic [W-1:0]    MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d & MASK;
  end
endmodule

// File: rtl/gpio_bidir_lane.sv
module gpio_bidir_lane
  import gpio_bank_pkg::*;
#(
  parameter int BASE  = 0,
  parameter int NPINS = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_dir,
  input  logic             wr_dat,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] pad_sync,
  output logic [REG_W-1:0] dir_q,
  output logic [REG_W-1:0] dat_q,
  output logic [REG_W-1:0] rd_dir,
  output logic [REG_W-1:0] rd_dat
);
  localparam logic [REG_W-1:0] MASK = lane_mask(BASE, NPINS);

  gpio_field_reg #(.W(REG_W), .MASK(MASK)) u_dir (
    .clk(clk), .rst_n(rst_n), .we(wr_dir), .d(wdata), .q(dir_q)
  );

  gpio_field_reg #(.W(REG_W), .MASK(MASK)) u_dat (
    .clk(clk), .rst_n(rst_n), .we(wr_dat), .d(wdata), .q(dat_q)
  );

  assign rd_dir = dir_q;
  assign rd_dat = merge_read(dat_q, dir_q, pad_sync) & MASK;
endmodule

// File: rtl/gpio_out_bank.sv
module gpio_out_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS  = 50,
  parameter bit OE_SEP = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic             wr_oen,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] lo_q,
  output logic [REG_W-1:0] hi_q,
  output logic [REG_W-1:0] oen_q,
  output logic [17:0]      drv_out,
  output logic [17:0]      drv_oe
);
  localparam logic [REG_W-1:0] LO_MASK = lane_mask(32, NPINS);
  localparam logic [REG_W-1:0] HI_MASK = hi_out_mask(NPINS);

  gpio_field_reg #(.W(REG_W), .MASK(LO_MASK)) u_lo (
    .clk(clk), .rst_n(rst_n), .we(wr_lo), .d(wdata), .q(lo_q)
  );

  gpio_field_reg #(.W(REG_W), .MASK(HI_MASK)) u_hi (
    .clk(clk), .rst_n(rst_n), .we(wr_hi), .d(wdata), .q(hi_q)
  );

  generate
    if (OE_SEP) begin : g_sep
      gpio_field_reg #(.W(REG_W), .MASK(LO_MASK)) u_oen (
        .clk(clk), .rst_n(rst_n), .we(wr_oen), .d(wdata), .q(oen_q)
      );
    end else begin : g_fixed
      assign oen_q = '0;
    end
  endgenerate

  assign drv_out = {hi_q[1:0], lo_q};
  assign drv_oe  = {hi_q[9:8], (OE_SEP ? oen_q : LO_MASK)};
endmodule

// File: rtl/gpio_bank_top.sv
module gpio_bank_top
  import gpio_bank_pkg::*;
#(
  parameter gpio_variant_e VARIANT     = GV_W50_PULL,
  parameter bit            OE_SEP      = 1'b0,
  parameter int            SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [REG_W-1:0]     wdata,
  output logic [REG_W-1:0]     rdata,
  input  logic [BIDIR_PINS-1:0] pad_in,
  output logic [MAX_PINS-1:0]  pad_out,
  output logic [MAX_PINS-1:0]  pad_oe,
  output logic [PULL_PINS-1:0] pull_en,
  output logic [PULL_PINS-1:0] pull_up
);
  localparam int NPINS    = variant_pins(VARIANT);
  localparam bit HAS_PULL = variant_has_pull(VARIANT);
  localparam logic [REG_W-1:0] PULL_MASK = 16'h7FFF;

  // address decode, brought out as named events
  logic sel_dir_lo, sel_dir_hi, sel_dat_lo, sel_dat_hi;
  logic sel_out_lo, sel_out_hi, sel_oen, sel_pen, sel_pup;
  logic addr_hit;
  logic wr_dir_lo, wr_dir_hi, wr_dat_lo, wr_dat_hi;
  logic wr_out_lo, wr_out_hi, wr_oen, wr_pen, wr_pup;

  assign sel_dir_lo = (addr == OFS_DIR_LO);
  assign sel_dir_hi = (addr == OFS_DIR_HI);
  assign sel_dat_lo = (addr == OFS_DAT_LO);
  assign sel_dat_hi = (addr == OFS_DAT_HI);
  assign sel_out_lo = (addr == OFS_OUT_LO);
  assign sel_out_hi = (addr == OFS_OUT_HI);
  assign sel_oen    = OE_SEP   && (addr == OFS_OE_SEP);
  assign sel_pen    = HAS_PULL && (addr == OFS_PL_EN);
  assign sel_pup    = HAS_PULL && (addr == OFS_PL_UP);

  assign addr_hit = sel_dir_lo | sel_dir_hi | sel_dat_lo | sel_dat_hi |
                    sel_out_lo | sel_out_hi | sel_oen | sel_pen | sel_pup;

  assign wr_dir_lo = wr_en & sel_dir_lo;
  assign wr_dir_hi = wr_en & sel_dir_hi;
  assign wr_dat_lo = wr_en & sel_dat_lo;
  assign wr_dat_hi = wr_en & sel_dat_hi;
  assign wr_out_lo = wr_en & sel_out_lo;
  assign wr_out_hi = wr_en & sel_out_hi;
  assign wr_oen    = wr_en & sel_oen;
  assign wr_pen    = wr_en & sel_pen;
  assign wr_pup    = wr_en & sel_pup;

  // pad input synchroniser
  logic [BIDIR_PINS-1:0] pad_sync;
  gpio_pad_sync #(.W(BIDIR_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_sync)
  );

  // bidirectional lanes
  logic [REG_W-1:0] lane_dir [2];
  logic [REG_W-1:0] lane_dat [2];
  logic [REG_W-1:0] lane_rdir [2];
  logic [REG_W-1:0] lane_rdat [2];
  logic             lane_wdir [2];
  logic             lane_wdat [2];

  assign lane_wdir[0] = wr_dir_lo;
  assign lane_wdir[1] = wr_dir_hi;
  assign lane_wdat[0] = wr_dat_lo;
  assign lane_wdat[1] = wr_dat_hi;

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_lane
      gpio_bidir_lane #(.BASE(g * REG_W), .NPINS(NPINS)) u_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_dir   (lane_wdir[g]),
        .wr_dat   (lane_wdat[g]),
        .wdata    (wdata),
        .pad_sync (pad_sync[g*REG_W +: REG_W]),
        .dir_q    (lane_dir[g]),
        .dat_q    (lane_dat[g]),
        .rd_dir   (lane_rdir[g]),
        .rd_dat   (lane_rdat[g])
      );
      assign pad_out[g*REG_W +: REG_W] = lane_dat[g];
      assign pad_oe [g*REG_W +: REG_W] = lane_dir[g];
    end
  endgenerate

  // output-only pins
  logic [REG_W-1:0] out_lo_q, out_hi_q, oen_q;
  logic [17:0]      drv_out, drv_oe;

  gpio_out_bank #(.NPINS(NPINS), .OE_SEP(OE_SEP)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_lo   (wr_out_lo),
    .wr_hi   (wr_out_hi),
    .wr_oen  (wr_oen),
    .wdata   (wdata),
    .lo_q    (out_lo_q),
    .hi_q    (out_hi_q),
    .oen_q   (oen_q),
    .drv_out (drv_out),
    .drv_oe  (drv_oe)
  );

  assign pad_out[MAX_PINS-1:BIDIR_PINS] = drv_out;
  assign pad_oe [MAX_PINS-1:BIDIR_PINS] = drv_oe;

  // pull control
  logic [REG_W-1:0] pen_q, pup_q;
  generate
    if (HAS_PULL) begin : g_pull
      gpio_field_reg #(.W(REG_W), .MASK(PULL_MASK)) u_pen (
        .clk(clk), .rst_n(rst_n), .we(wr_pen), .d(wdata), .q(pen_q)
      );
      gpio_field_reg #(.W(REG_W), .MASK(PULL_MASK)) u_pup (
        .clk(clk), .rst_n(rst_n), .we(wr_pup), .d(wdata), .q(pup_q)
      );
    end else begin : g_nopull
      assign pen_q = '0;
      assign pup_q = '0;
    end
  endgenerate

  assign pull_en = pen_q[PULL_PINS-1:0];
  assign pull_up = pup_q[PULL_PINS-1:0];

  // read mux
  always_comb begin
    rdata = '0;
    if (sel_dir_lo) rdata = rdata | lane_rdir[0];
    if (sel_dir_hi) rdata = rdata | lane_rdir[1];
    if (sel_dat_lo) rdata = rdata | lane_rdat[0];
    if (sel_dat_hi) rdata = rdata | lane_rdat[1];
    if (sel_out_lo) rdata = rdata | out_lo_q;
    if (sel_out_hi) rdata = rdata | out_hi_q;
    if (sel_oen)    rdata = rdata | oen_q;
    if (sel_pen)    rdata = rdata | pen_q;
    if (sel_pup)    rdata = rdata | pup_q;
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter gpio_variant_e VARIANT = GV_W50_PULL,
  parameter bit            OE_SEP  = 1'b0
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [REG_W-1:0]     wdata,
  input logic [REG_W-1:0]     rdata,
  input logic [MAX_PINS-1:0]  pad_out,
  input logic [MAX_PINS-1:0]  pad_oe,
  input logic [PULL_PINS-1:0] pull_en,
  input logic                 addr_hit,
  input logic                 wr_dir_lo,
  input logic                 wr_dat_lo,
  input logic                 wr_out_hi
);
  localparam int NPINS = variant_pins(VARIANT);
  localparam bit HAS_PULL = variant_has_pull(VARIANT);
  localparam logic [1:0] EN48_MASK = lane_mask(48, NPINS) & 2'b11;
  localparam logic [MAX_PINS-1:0] PIN_MASK = {MAX_PINS{1'b1}} >> (MAX_PINS - NPINS);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe[31:0] == '0 && pull_en == '0));

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir_lo |=> pad_oe[15:0] == $past(wdata));

  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dat_lo |=> $stable(pad_out[15:0]));

  // R7
  hi_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out_hi |=> pad_oe[49:48] == ($past(wdata[9:8]) & EN48_MASK));

  // R8
  absent_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out | pad_oe) & ~PIN_MASK) == '0);

  // R9
  pull_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_PULL |-> pull_en == '0);

  // R10
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |-> rdata == '0);
endmodule

bind gpio_bank_top gpio_bank_chk #(.VARIANT(VARIANT), .OE_SEP(OE_SEP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wdata     (wdata),
  .rdata     (rdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .pull_en   (pull_en),
  .addr_hit  (addr_hit),
  .wr_dir_lo (wr_dir_lo),
  .wr_dat_lo (wr_dat_lo),
  .wr_out_hi (wr_out_hi)
);

// File: tb/tb_gpio_bank_top.sv
module tb_gpio_bank_top;
  import gpio_bank_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [8:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [31:0] pad_in = '0;

  logic [15:0] rd   [2];
  logic [49:0] pout [2];
  logic [49:0] poe  [2];
  logic [14:0] pen  [2];
  logic [14:0] pup  [2];

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  gpio_bank_top #(.VARIANT(GV_W50_PULL), .OE_SEP(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rd[0]), .pad_in(pad_in), .pad_out(pout[0]), .pad_oe(poe[0]),
    .pull_en(pen[0]), .pull_up(pup[0])
  );

  gpio_bank_top #(.VARIANT(GV_W36), .OE_SEP(1'b1)) dut36 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rd[1]), .pad_in(pad_in), .pad_out(pout[1]), .pad_oe(poe[1]),
    .pull_en(pen[1]), .pull_up(pup[1])
  );

  // model: index 0 dirl 1 dirh 2 datl 3 dath 4 olo 5 ohi 6 oen 7 pen 8 pup
  logic [15:0] m [2][9];
  logic [31:0] pad_seen;

  function automatic logic [8:0] idx_addr(int i);
    case (i)
      0: return 9'h000; 1: return 9'h002; 2: return 9'h004;
      3: return 9'h006; 4: return 9'h01C; 5: return 9'h01E;
      6: return 9'h020; 7: return 9'h1E0; 8: return 9'h1E2;
      default: return 9'h1FE;
    endcase
  endfunction

  // dut: 50 pins, pull, shared enables; dut36: 36 pins, separate enables
  function automatic logic [15:0] bmask(int k, int i);
    if (i <= 3) return 16'hFFFF;
    case (i)
      4: return (k == 0) ? 16'hFFFF : 16'h000F;
      5: return (k == 0) ? 16'h0303 : 16'h0000;
      6: return (k == 0) ? 16'h0000 : 16'h000F;
      7, 8: return (k == 0) ? 16'h7FFF : 16'h0000;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] exp_rd(int k, int i);
    if (i > 8) return 16'h0000;
    if (i == 2) return (m[k][2] & m[k][0]) | (pad_seen[15:0] & ~m[k][0]);
    if (i == 3) return (m[k][3] & m[k][1]) | (pad_seen[31:16] & ~m[k][1]);
    return m[k][i];
  endfunction

  function automatic logic [49:0] exp_out(int k);
    return {m[k][5][1:0], m[k][4], m[k][3], m[k][2]};
  endfunction

  function automatic logic [49:0] exp_oe(int k);
    return {m[k][5][9:8], (k == 0 ? bmask(0, 4) : m[k][6]), m[k][1], m[k][0]};
  endfunction

  task automatic cmp(string req, string what, logic [49:0] act, logic [49:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(int i, logic [15:0] d);
    @(negedge clk);
    addr = idx_addr(i); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (i <= 8) for (int k = 0; k < 2; k++) m[k][i] = d & bmask(k, i);
  endtask

  task automatic set_pad(logic [31:0] v);
    @(negedge clk);
    pad_in = v;
    @(negedge clk);
    @(negedge clk);
    pad_seen = v;
  endtask

  task automatic check_all(string req);
    for (int k = 0; k < 2; k++) begin
      cmp(req, "pad_out", pout[k], exp_out(k));
      cmp(req, "pad_oe", poe[k], exp_oe(k));
      cmp(req, "pull_en", {35'd0, pen[k]}, {35'd0, m[k][7][14:0]});
      cmp(req, "pull_up", {35'd0, pup[k]}, {35'd0, m[k][8][14:0]});
    end
    for (int i = 0; i <= 9; i++) begin
      addr = idx_addr(i);
      #1;
      for (int k = 0; k < 2; k++) cmp(req, "rdata", {34'd0, rd[k]}, {34'd0, exp_rd(k, i)});
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int i;
    for (int k = 0; k < 2; k++) for (int j = 0; j < 9; j++) m[k][j] = '0;
    pad_seen = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R3: data held while input, visible once output
    wr(2, 16'hA5A5);
    check_all("R3");
    wr(0, 16'hFFFF);
    check_all("R2");
    wr(0, 16'h0000);
    wr(0, 16'hFFFF);
    cmp("R3", "held data", {34'd0, pout[0][15:0]}, {34'd0, 16'hA5A5});

    // R4: pad latency and mixed read
    wr(0, 16'h00FF);
    @(negedge clk);
    pad_in = 32'h1234_5678;
    @(negedge clk);
    addr = idx_addr(2); #1;
    cmp("R4", "one edge old", {34'd0, rd[0]}, {34'd0, exp_rd(0, 2)});
    @(negedge clk);
    pad_seen = pad_in;
    check_all("R4");
    wr(1, 16'hF0F0);
    wr(3, 16'h0FF0);
    check_all("R4");

    // R5 R6 R7 R8: output-only pins
    wr(4, 16'hFFFF);
    wr(5, 16'hFFFF);
    check_all("R5");
    wr(6, 16'h0005);
    check_all("R6");
    wr(5, 16'h0201);
    check_all("R7");
    cmp("R8", "dut36 high pins", {14'd0, pout[1][49:36], poe[1][49:36]}, '0);

    // R9: pull control, bit 15 ignored
    wr(7, 16'hFFFF);
    wr(8, 16'h8001);
    check_all("R9");

    // R10: unmapped address
    wr(9, 16'hFFFF);
    check_all("R10");

    // random mix
    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(0, 7) == 0) set_pad($urandom());
      i = $urandom_range(0, 9);
      d = 16'($urandom());
      wr(i, d);
      check_all("R5");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule